// File: doc/BRIEF.md
# Condition-Gated Barrel Shift Unit

This block performs one of five shift operations on a 32-bit operand in a single pass and registers the outcome one clock later. The operations are arithmetic shift right, logical shift right, logical shift left, rotate right, and a one-bit rotate right that brings the carry flag in at the top. The shift distance comes from a 6-bit immediate field or from the low byte of a second register value. The result is offered to the register file as a write request. That request targets the named destination index, or the source index when no destination is named.

The block holds a 4-bit flag register. From most significant to least significant its bits are N, Z, C and V. A 4-bit condition code is tested against these flags, and it decides whether the operation takes effect at all. When the operation commits and the set-flags input is high, N, Z and C are refreshed from the result and V is kept. In every other case all four flags stay as they were.

Top module: `shf_unit`

## Requirements
- R1: Operation code 0 is an arithmetic right shift. It fills vacated high bits with source bit 31, C takes the last bit shifted out, and any distance of 32 or more gives 32 copies of bit 31 with C equal to bit 31.
- R2: Operation code 1 is a logical right shift with zero fill, and C takes the last bit shifted out. A distance of 32 gives zero with C equal to source bit 31. A distance above 32 gives zero with C equal to 0.
- R3: Operation code 2 is a logical left shift with zero fill, and C takes the last bit shifted out. A distance of 32 gives zero with C equal to source bit 0. A distance above 32 gives zero with C equal to 0.
- R4: Operation code 3 is a rotate right by the distance modulo 32, and C equals bit 31 of the result. A nonzero multiple of 32 returns the operand unchanged.
- R5: Operation code 4 moves the operand right by exactly one bit whatever the distance inputs say. It places the current C in bit 31, and the new C is source bit 0.
- R6: When amt_from_reg is 0 the distance is amt_imm. When amt_from_reg is 1 the distance is amt_reg[7:0], and bits [31:8] have no effect.
- R7: A distance of zero on codes 0 to 3 passes the operand through unchanged and leaves C unchanged.
- R8: On a committed operation with set_flags high, N is result bit 31 and Z is 1 exactly when the result is zero. V never changes.
- R9: When set_flags is low, all four flags keep their previous values.
- R10: wr_idx is dst_idx when dst_en is 1 and src_idx otherwise.
- R11: The condition codes are: 0 Z set, 1 Z clear, 2 C set, 3 C clear, 4 N set, 5 N clear, 6 V set, 7 V clear, 8 C set and Z clear, 9 C clear or Z set, 10 N equal to V, 11 N not equal to V, 12 Z clear and N equal to V, 13 Z set or N not equal to V, 14 and 15 always.
- R12: When the condition fails, wr_en stays 0 and the flags do not change.
- R13: After reset, wr_en is 0 and the flags are 0000. A committed operation raises wr_en with its result one cycle after op_valid, and wr_en is 0 in cycles with no committed operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 3 | Operation code (0 ASR, 1 LSR, 2 LSL, 3 ROR, 4 rotate through carry) |
| src_val | input | 32 | Source operand value |
| src_idx | input | 4 | Source register index |
| dst_en | input | 1 | A separate destination is named |
| dst_idx | input | 4 | Destination register index |
| amt_from_reg | input | 1 | Take the distance from amt_reg instead of amt_imm |
| amt_imm | input | 6 | Immediate distance |
| amt_reg | input | 32 | Distance register value (low byte used) |
| cond | input | 4 | Condition code |
| set_flags | input | 1 | Update flags from the result |
| wr_en | output | 1 | Register write request |
| wr_idx | output | 4 | Register index to write |
| wr_data | output | 32 | Value to write |
| flags | output | 4 | Current flags {N,Z,C,V} |

## Verification
The bench aims at the distance boundaries 0, 1, 31, 32, 33 and values above 255 with upper amount bits set. A design that mishandles one of these would return a stale operand, zero the sign fill, take the carry from the wrong edge, or let bit 8 of the amount register leak into the distance. It feeds the carry into the one-bit rotate after earlier shifts have set and cleared C. A design that takes the wrong carry or ignores set_flags shows a wrong bit 31 or a changed C. Every condition code is checked against flag states built up by earlier shifts. A design with a swapped condition code writes when it should not, or changes the flags on a failed condition.

// File: rtl/shf_pkg.sv
package shf_pkg;
    typedef enum logic [2:0] {
        OP_ASR = 3'd0,
        OP_LSR = 3'd1,
        OP_LSL = 3'd2,
        OP_ROR = 3'd3,
        OP_RCX = 3'd4
    } shf_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } shf_flags_t;
endpackage

// File: rtl/shf_core.sv
module shf_core
    import shf_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input  logic [2:0]    op,
    input  logic [W-1:0]  a,
    input  logic [AW-1:0] n,
    input  logic          cin,
    output logic [W-1:0]  res,
    output logic          cout
);
    localparam int CW = $clog2(W + 2);
    localparam int RW = $clog2(W);

    logic [CW-1:0]        n_log;
    logic [CW-1:0]        n_ari;
    logic [W:0]           left_ext;
    logic [W:0]           right_ext;
    logic signed [W:0]    arith_ext;
    logic [2*W-1:0]       rot_ext;

    always_comb begin
        n_log     = (n > AW'(W + 1)) ? CW'(W + 1) : n[CW-1:0];
        n_ari     = (n > AW'(W))     ? CW'(W)     : n[CW-1:0];
        left_ext  = {1'b0, a} << n_log;
        right_ext = {a, 1'b0} >> n_log;
        arith_ext = $signed({a, 1'b0}) >>> n_ari;
        rot_ext   = {a, a} >> n[RW-1:0];
        res       = a;
        cout      = cin;
        if (op == OP_RCX) begin
            res  = {cin, a[W-1:1]};
            cout = a[0];
        end else if (n != '0) begin
            case (op)
                OP_ASR: begin res = arith_ext[W:1]; cout = arith_ext[0]; end
                OP_LSR: begin res = right_ext[W:1]; cout = right_ext[0]; end
                OP_LSL: begin res = left_ext[W-1:0]; cout = left_ext[W]; end
                OP_ROR: begin res = rot_ext[W-1:0]; cout = rot_ext[W-1]; end
                default: begin res = a; cout = cin; end
            endcase
        end
    end
endmodule

// File: rtl/shf_cond.sv
module shf_cond
    import shf_pkg::*;
(
    input  logic [3:0]  cond,
    input  shf_flags_t  fl,
    output logic        pass
);
    always_comb begin
        case (cond[3:1])
            3'd0: pass = fl.z;
            3'd1: pass = fl.c;
            3'd2: pass = fl.n;
            3'd3: pass = fl.v;
            3'd4: pass = fl.c & ~fl.z;
            3'd5: pass = (fl.n == fl.v);
            3'd6: pass = ~fl.z & (fl.n == fl.v);
            default: pass = 1'b1;
        endcase
        if (cond[0] && cond[3:1] != 3'd7)
            pass = ~pass;
    end
endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int W  = 32,
    parameter int IW = 4,
    parameter int AW = 8,
    parameter int MW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [2:0]    op_kind,
    input  logic [W-1:0]  src_val,
    input  logic [IW-1:0] src_idx,
    input  logic          dst_en,
    input  logic [IW-1:0] dst_idx,
    input  logic          amt_from_reg,
    input  logic [MW-1:0] amt_imm,
    input  logic [W-1:0]  amt_reg,
    input  logic [3:0]    cond,
    input  logic          set_flags,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [W-1:0]  wr_data,
    output logic [3:0]    flags
);
    typedef struct packed {
        logic          wr_en;
        logic [IW-1:0] wr_idx;
        logic [W-1:0]  wr_data;
        shf_flags_t    fl;
    } state_t;

    state_t        st_d, st_q;
    logic [AW-1:0] amt_sel;
    logic [W-1:0]  core_res;
    logic          core_c;
    logic          cond_ok;
    logic          commit;
    logic          unused_amt_hi;

    assign unused_amt_hi = ^amt_reg[W-1:AW];
    assign amt_sel = amt_from_reg ? amt_reg[AW-1:0] : AW'(amt_imm);

    shf_core #(.W(W), .AW(AW)) u_core (
        .op   (op_kind),
        .a    (src_val),
        .n    (amt_sel),
        .cin  (st_q.fl.c),
        .res  (core_res),
        .cout (core_c)
    );

    shf_cond u_cond (
        .cond (cond),
        .fl   (st_q.fl),
        .pass (cond_ok)
    );

    assign commit = op_valid & cond_ok;

    always_comb begin
        st_d        = st_q;
        st_d.wr_en  = commit;
        if (commit) begin
            st_d.wr_idx  = dst_en ? dst_idx : src_idx;
            st_d.wr_data = core_res;
            if (set_flags) begin
                st_d.fl.n = core_res[W-1];
                st_d.fl.z = (core_res == '0);
                st_d.fl.c = core_c;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en   = st_q.wr_en;
    assign wr_idx  = st_q.wr_idx;
    assign wr_data = st_q.wr_data;
    assign flags   = st_q.fl;

    AST_FLAGS_HOLD_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_flags) |=> (flags == $past(flags))); // R9
    AST_COND_FAIL_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !cond_ok) |=> (!wr_en && flags == $past(flags))); // R12
    AST_V_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flags[0] == $past(flags[0]))); // R8
    AST_NZ_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && set_flags) |=> (flags[3] == wr_data[W-1] && flags[2] == (wr_data == '0))); // R8
    AST_IDX_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (wr_idx == (($past(dst_en)) ? $past(dst_idx) : $past(src_idx)))); // R10
    AST_IDLE_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid) |=> !wr_en); // R13
    AST_ZERO_DIST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && amt_sel == '0 && op_kind != OP_RCX) |=> (wr_data == $past(src_val))); // R7
    AST_RCX_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op_kind == OP_RCX) |=> (wr_data[W-1] == $past(flags[1]))); // R5
endmodule

// File: tb/shf_unit_bench.sv
module shf_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_kind = '0;
    logic [31:0] src_val = '0;
    logic [3:0]  src_idx = '0;
    logic        dst_en = 1'b0;
    logic [3:0]  dst_idx = '0;
    logic        amt_from_reg = 1'b0;
    logic [5:0]  amt_imm = '0;
    logic [31:0] amt_reg = '0;
    logic [3:0]  cond = 4'd14;
    logic        set_flags = 1'b0;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [31:0] wr_data;
    logic [3:0]  flags;

    int checks = 0;
    int errors = 0;
    logic [3:0] mflags = 4'b0000;
    bit done = 0;

    shf_unit u_shf_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .src_val(src_val), .src_idx(src_idx), .dst_en(dst_en), .dst_idx(dst_idx),
        .amt_from_reg(amt_from_reg), .amt_imm(amt_imm), .amt_reg(amt_reg),
        .cond(cond), .set_flags(set_flags), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .flags(flags)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit cond_pass(logic [3:0] c, logic [3:0] f);
        bit n = f[3], z = f[2], cy = f[1], v = f[0];
        case (c)
            4'd0: return z;        4'd1: return !z;
            4'd2: return cy;       4'd3: return !cy;
            4'd4: return n;        4'd5: return !n;
            4'd6: return v;        4'd7: return !v;
            4'd8: return cy && !z; 4'd9: return !cy || z;
            4'd10: return n == v;  4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            default: return 1'b1;
        endcase
    endfunction

    task automatic model(input logic [2:0] op, input logic [31:0] a, input int n,
                         input logic cin, output logic [31:0] r, output logic co);
        for (int i = 0; i < 32; i++) begin
            case (op)
                3'd0: r[i] = (i + n < 32) ? a[i+n] : a[31];
                3'd1: r[i] = (i + n < 32) ? a[i+n] : 1'b0;
                3'd2: r[i] = (i >= n) ? a[i-n] : 1'b0;
                3'd3: r[i] = a[(i + n) % 32];
                default: r[i] = (i == 31) ? cin : a[i+1];
            endcase
        end
        co = cin;
        if (op == 3'd4) co = a[0];
        else if (n != 0) begin
            case (op)
                3'd0: co = (n <= 32) ? a[n-1] : a[31];
                3'd1: co = (n <= 32) ? a[n-1] : 1'b0;
                3'd2: co = (n <= 32) ? a[32-n] : 1'b0;
                default: co = a[(n - 1) % 32];
            endcase
        end
    endtask

    task automatic run(string tag, logic [2:0] op, logic [31:0] a, bit from_reg,
                       logic [5:0] imm, logic [31:0] rv, bit setf, logic [3:0] c,
                       bit de, logic [3:0] di, logic [3:0] si);
        logic [31:0] er;
        logic        ec;
        int          n;
        bit          ok;
        n = from_reg ? int'(rv[7:0]) : int'(imm);
        model(op, a, n, mflags[1], er, ec);
        ok = cond_pass(c, mflags);
        @(negedge clk);
        op_valid = 1'b1; op_kind = op; src_val = a; amt_from_reg = from_reg;
        amt_imm = imm; amt_reg = rv; set_flags = setf; cond = c;
        dst_en = de; dst_idx = di; src_idx = si;
        @(negedge clk);
        op_valid = 1'b0;
        check({tag, " wr_en"}, 32'(wr_en), 32'(ok));
        if (ok) begin
            check({tag, " data"}, wr_data, er);
            check({tag, " idx R10"}, 32'(wr_idx), 32'(de ? di : si));
            if (setf) mflags = {er[31], er == 32'd0, ec, mflags[0]};
        end
        check({tag, " flags"}, 32'(flags), 32'(mflags));
    endtask

    task automatic t_reset();
        check("R13 reset wr_en", 32'(wr_en), 32'd0);
        check("R13 reset flags", 32'(flags), 32'd0);
    endtask

    task automatic t_asr();
        run("R1 asr 4",  3'd0, 32'h8000_0018, 0, 6'd4, 0, 1, 4'd14, 0, 0, 4'd2);
        run("R1 asr 31", 3'd0, 32'h8000_0001, 0, 6'd31, 0, 1, 4'd14, 0, 0, 4'd2);
        run("R1 asr 32", 3'd0, 32'h8123_4567, 0, 6'd32, 0, 1, 4'd14, 0, 0, 4'd2);
        run("R1 asr 200", 3'd0, 32'h4000_0000, 1, 6'd0, 32'd200, 1, 4'd14, 0, 0, 4'd2);
    endtask

    task automatic t_lsr();
        run("R2 lsr 1",  3'd1, 32'hF000_0003, 0, 6'd1, 0, 1, 4'd14, 1, 4'd7, 4'd1);
        run("R2 lsr 32", 3'd1, 32'h8000_0000, 0, 6'd32, 0, 1, 4'd14, 0, 0, 4'd1);
        run("R2 lsr 33", 3'd1, 32'hFFFF_FFFF, 0, 6'd33, 0, 1, 4'd14, 0, 0, 4'd1);
    endtask

    task automatic t_lsl();
        run("R3 lsl 8",  3'd2, 32'h01FF_0080, 0, 6'd8, 0, 1, 4'd14, 0, 0, 4'd3);
        run("R3 lsl 32", 3'd2, 32'h0000_0001, 0, 6'd32, 0, 1, 4'd14, 0, 0, 4'd3);
        run("R3 lsl 40", 3'd2, 32'hFFFF_FFFF, 0, 6'd40, 0, 1, 4'd14, 0, 0, 4'd3);
    endtask

    task automatic t_ror();
        run("R4 ror 4",  3'd3, 32'h1234_5678, 0, 6'd4, 0, 1, 4'd14, 0, 0, 4'd4);
        run("R4 ror 32", 3'd3, 32'h8765_4321, 0, 6'd32, 0, 1, 4'd14, 0, 0, 4'd4);
        run("R4 ror 36", 3'd3, 32'h0000_00F0, 1, 6'd0, 32'd36, 1, 4'd14, 0, 0, 4'd4);
    endtask

    task automatic t_rcx();
        run("R5 setc", 3'd1, 32'h0000_0001, 0, 6'd1, 0, 1, 4'd14, 0, 0, 4'd5);
        run("R5 rcx c1", 3'd4, 32'h0000_0002, 0, 6'd9, 0, 1, 4'd14, 0, 0, 4'd5);
        run("R5 rcx c0", 3'd4, 32'h0000_0003, 0, 6'd0, 0, 1, 4'd14, 0, 0, 4'd5);
        run("R5 rcx noset", 3'd4, 32'h0000_0000, 0, 6'd0, 0, 0, 4'd14, 0, 0, 4'd5);
    endtask

    task automatic t_amount();
        run("R6 reg hi ignored", 3'd2, 32'h0000_00FF, 1, 6'd20, 32'hFFFF_FF04, 1, 4'd14, 0, 0, 4'd6);
        run("R6 reg byte", 3'd1, 32'hABCD_0000, 1, 6'd1, 32'h0000_0110, 1, 4'd14, 0, 0, 4'd6);
        run("R7 zero dist", 3'd0, 32'h8000_0000, 1, 6'd5, 32'h0000_0100, 1, 4'd14, 0, 0, 4'd6);
        run("R7 zero imm", 3'd3, 32'h0000_0000, 0, 6'd0, 0, 1, 4'd14, 0, 0, 4'd6);
    endtask

    task automatic t_noset();
        run("R9 noset", 3'd2, 32'h0000_0000, 0, 6'd1, 0, 0, 4'd14, 1, 4'd9, 4'd3);
        run("R9 noset2", 3'd0, 32'h8000_0000, 0, 6'd3, 0, 0, 4'd14, 0, 0, 4'd3);
    endtask

    task automatic t_cond();
        // Z=1 C=0 N=0
        run("R8 make z", 3'd1, 32'h0000_0000, 0, 6'd4, 0, 1, 4'd14, 0, 0, 4'd0);
        for (int c = 0; c < 16; c++)
            run("R11 cond z", 3'd2, 32'h0000_0001, 0, 6'd1, 0, 0, 4'(c), 0, 0, 4'd8);
        // N=1 C=1 Z=0
        run("R8 make nc", 3'd0, 32'h8000_0001, 0, 6'd1, 0, 1, 4'd14, 0, 0, 4'd0);
        for (int c = 0; c < 16; c++)
            run("R11 cond nc", 3'd2, 32'h0000_0001, 0, 6'd1, 0, 0, 4'(c), 0, 0, 4'd8);
        run("R12 fail noflag", 3'd1, 32'h0000_0000, 0, 6'd1, 0, 1, 4'd0, 0, 0, 4'd8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R13 idle wr_en", 32'(wr_en), 32'd0);
        t_asr();
        t_lsr();
        t_lsl();
        t_ror();
        t_rcx();
        t_amount();
        t_noset();
        t_cond();
        @(negedge clk);
        check("R13 idle after", 32'(wr_en), 32'd0);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R13 actual=hung expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule